// File: doc/BRIEF.md
# Two-Level State Controller with History Re-Entry

This controller runs a small hierarchical state machine. It has one composite region and one plain state that sits outside it, called Idle. The region holds five leaf substates, numbered 0 to 4. Whenever the region is occupied, exactly one of its substates is current.

The region can be entered in two ways. A plain entry always starts in substate 0. A resume entry goes back to the substate that was current when the region was last left. Inside the region, a step pulse moves the machine through the substates in a ring. A leave pulse returns the machine to Idle.

One substate is supervised. If the machine stays in it for a set number of clock cycles and no keep-alive pulse arrives, the machine jumps to a fixed target substate. It also raises a one-cycle timeout flag.

All event inputs are single-cycle pulses. Each clock edge computes every new value from the values held before that edge, and commits them all at that edge.

Top module: `hfsm_top`

## Requirements
- R1: `activeState` is always one-hot. Bits 0..4 stand for substates 0..4 and bit 5 stands for Idle. `inS` is high exactly when one of bits 0..4 is set.
- R2: After a synchronous reset the machine is in Idle (`activeState` = 6'b100000). The resume memory is empty and `timeoutPulse` is low.
- R3: A plain entry (`evEnterDef`) taken from Idle always lands in substate 0, whatever substate was current before.
- R4: A resume entry (`evEnterHist`) taken from Idle lands in the substate that was current at the most recent leave. If the region has never been left since reset, it lands in substate 0.
- R5: `evExit` inside the region moves the machine to Idle and records the substate that was current. The leave takes priority over a step and over a timeout in the same cycle. When a step arrives in that same cycle, the substate held before the step is the one recorded.
- R6: `evAdvance` inside the region, with no leave pending, moves substate k to k+1, and substate 4 to substate 0.
- R7: The supervised substate is 0 and the timeout target is substate 3.
  - The machine takes the timeout edge to substate 3 after TIMEOUT_CYCLES consecutive cycles in substate 0 with no `evWatch`.
  - Every `evWatch` pulse restarts that count.
  - `timeoutPulse` is high for exactly the one cycle in which substate 3 is first shown after the timeout edge.
- R8: Events that do not apply to the current level change nothing:
  - entry pulses while inside the region;
  - `evExit`, `evAdvance` and `evWatch` while in Idle.
- R9: When both entry pulses arrive together at Idle, the plain entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evEnterDef | input | 1 | Plain entry pulse |
| evEnterHist | input | 1 | Resume entry pulse |
| evExit | input | 1 | Leave-region pulse |
| evAdvance | input | 1 | Step to next substate pulse |
| evWatch | input | 1 | Keep-alive pulse for the supervised substate |
| activeState | output | 6 | One-hot current leaf state; bit 5 is Idle |
| inS | output | 1 | High while the region is occupied |
| timeoutPulse | output | 1 | One-cycle timeout event |

## Verification
The bound checker enforces the following on every cycle:
- the one-hot shape of the state and its agreement with `inS`;
- the landing state of plain entry and of leave;
- the ring step from substate 4 back to 0;
- that Idle stays put when no entry arrives;
- that the timeout flag lasts one cycle and coincides with the target substate.

Some behaviours need a remembered past, so only the bench scenarios show them:
- resume entry returning the right substate;
- the empty-memory fallback to substate 0;
- the pre-step substate being recorded when a leave and a step coincide;
- the exact cycle count before a timeout, and its restart on a keep-alive pulse.

// File: rtl/hfsm_pkg.sv
package hfsm_pkg;
  // Strobes sent from the control to the datapath on each clock edge
  typedef struct packed {
    logic saveHist;     // leaving the region: record the current substate
    logic cntInc;       // staying in the supervised substate with no keep-alive
    logic fireTimeout;  // timeout edge taken on this edge
  } dpStrobe_t;
endpackage

// File: rtl/hfsm_ctrl.sv
module hfsm_ctrl
  import hfsm_pkg::*;
#(
  parameter int N_SUB      = 5,
  parameter int WATCH_IDX  = 0,
  parameter int TARGET_IDX = 3,
  parameter int SW         = $clog2(N_SUB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evEnterDef,
  input  logic          evEnterHist,
  input  logic          evExit,
  input  logic          evAdvance,
  input  logic          evWatch,
  input  logic          histValid,
  input  logic [SW-1:0] histIdx,
  input  logic          timeoutHit,
  output logic [SW-1:0] state,
  output dpStrobe_t     strobe
);
  localparam logic [SW-1:0] OUT_CODE = SW'(N_SUB);
  localparam logic [SW-1:0] LAST_SUB = SW'(N_SUB - 1);
  localparam logic [SW-1:0] WATCH_C  = SW'(WATCH_IDX);
  localparam logic [SW-1:0] TARGET_C = SW'(TARGET_IDX);

  logic [SW-1:0] nextState;
  logic          inRegion;
  logic          toFire;

  assign inRegion = (state != OUT_CODE);

  // The timeout edge needs: supervised substate, no leave, no step,
  // no keep-alive, and a full count.
  assign toFire = inRegion && !evExit && !evAdvance && (state == WATCH_C)
                  && !evWatch && timeoutHit;

  always_comb begin
    nextState = state;
    if (!inRegion) begin
      if (evEnterDef)       nextState = '0;
      else if (evEnterHist) nextState = histValid ? histIdx : '0;
    end else begin
      if (evExit)         nextState = OUT_CODE;
      else if (evAdvance) nextState = (state == LAST_SUB) ? '0 : state + SW'(1);
      else if (toFire)    nextState = TARGET_C;
    end
  end

  always_comb begin
    strobe.saveHist    = inRegion && evExit;
    strobe.fireTimeout = toFire;
    strobe.cntInc      = (state == WATCH_C) && (nextState == WATCH_C) && !evWatch;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= OUT_CODE;
    else     state <= nextState;
  end
endmodule

// File: rtl/hfsm_dp.sv
module hfsm_dp
  import hfsm_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 20,
  parameter int SW             = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] state,
  input  dpStrobe_t     strobe,
  output logic          histValid,
  output logic [SW-1:0] histIdx,
  output logic          timeoutHit,
  output logic          timeoutPulse
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] dwellCnt;

  assign timeoutHit = (dwellCnt == LAST_CNT);

  // Resume memory: written only on the edge that leaves the region.
  always_ff @(posedge clk) begin
    if (rst) begin
      histValid <= 1'b0;
      histIdx   <= '0;
    end else if (strobe.saveHist) begin
      histValid <= 1'b1;
      histIdx   <= state;
    end
  end

  // Dwell counter: counts up while staying supervised; otherwise restarts.
  always_ff @(posedge clk) begin
    if (rst)                dwellCnt <= '0;
    else if (strobe.cntInc) dwellCnt <= dwellCnt + CW'(1);
    else                    dwellCnt <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) timeoutPulse <= 1'b0;
    else     timeoutPulse <= strobe.fireTimeout;
  end
endmodule

// File: rtl/hfsm_top.sv
module hfsm_top
  import hfsm_pkg::*;
#(
  parameter int N_SUB          = 5,
  parameter int TIMEOUT_CYCLES = 20,
  parameter int WATCH_IDX      = 0,
  parameter int TARGET_IDX     = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           evEnterDef,
  input  logic           evEnterHist,
  input  logic           evExit,
  input  logic           evAdvance,
  input  logic           evWatch,
  output logic [N_SUB:0] activeState,
  output logic           inS,
  output logic           timeoutPulse
);
  localparam int SW = $clog2(N_SUB + 1);

  logic [SW-1:0] state;
  logic [SW-1:0] histIdx;
  logic          histValid;
  logic          timeoutHit;
  dpStrobe_t     strobe;

  hfsm_ctrl #(
    .N_SUB(N_SUB), .WATCH_IDX(WATCH_IDX), .TARGET_IDX(TARGET_IDX), .SW(SW)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .evEnterDef(evEnterDef), .evEnterHist(evEnterHist),
    .evExit(evExit), .evAdvance(evAdvance), .evWatch(evWatch),
    .histValid(histValid), .histIdx(histIdx), .timeoutHit(timeoutHit),
    .state(state), .strobe(strobe)
  );

  hfsm_dp #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .SW(SW)
  ) u_dp (
    .clk(clk), .rst(rst), .state(state), .strobe(strobe),
    .histValid(histValid), .histIdx(histIdx),
    .timeoutHit(timeoutHit), .timeoutPulse(timeoutPulse)
  );

  for (genvar i = 0; i <= N_SUB; i++) begin : g_onehot
    assign activeState[i] = (state == SW'(i));
  end

  assign inS = |activeState[N_SUB-1:0];
endmodule

// File: rtl/hfsm_chk.sv
module hfsm_chk #(
  parameter int N_SUB      = 5,
  parameter int TARGET_IDX = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           evEnterDef,
  input logic           evEnterHist,
  input logic           evExit,
  input logic           evAdvance,
  input logic [N_SUB:0] activeState,
  input logic           inS,
  input logic           timeoutPulse
);
  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(activeState) == 1);                                          // R1

  AST_REGION_FLAG: assert property (@(posedge clk) disable iff (rst)
    inS == !activeState[N_SUB]);                                            // R1

  AST_PLAIN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!inS && evEnterDef) |=> activeState[0]);                               // R3

  AST_LEAVE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (inS && evExit) |=> activeState[N_SUB]);                                // R5

  AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst)
    (activeState[N_SUB-1] && !evExit && evAdvance) |=> activeState[0]);     // R6

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    timeoutPulse |=> !timeoutPulse);                                        // R7

  AST_PULSE_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    timeoutPulse |-> activeState[TARGET_IDX]);                              // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!inS && !evEnterDef && !evEnterHist) |=> !inS);                        // R8
endmodule

bind hfsm_top hfsm_chk #(.N_SUB(N_SUB), .TARGET_IDX(TARGET_IDX)) u_chk (
  .clk(clk), .rst(rst), .evEnterDef(evEnterDef), .evEnterHist(evEnterHist),
  .evExit(evExit), .evAdvance(evAdvance), .activeState(activeState),
  .inS(inS), .timeoutPulse(timeoutPulse)
);

// File: tb/hfsm_top_tb.sv
module hfsm_top_tb;
  localparam int NS  = 5;
  localparam int TO  = 20;
  localparam int OUT = NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evEnterDef = 0, evEnterHist = 0, evExit = 0, evAdvance = 0, evWatch = 0;
  logic [NS:0] activeState;
  logic inS, timeoutPulse;

  int compared = 0;
  int mismatched = 0;

  // Reference state of the bench
  int mState, mHist, mCnt;
  bit mHistValid, mPulse;

  always #4 clk = ~clk;

  hfsm_top #(.N_SUB(NS), .TIMEOUT_CYCLES(TO), .WATCH_IDX(0), .TARGET_IDX(3)) u_dut (
    .clk(clk), .rst(rst), .evEnterDef(evEnterDef), .evEnterHist(evEnterHist),
    .evExit(evExit), .evAdvance(evAdvance), .evWatch(evWatch),
    .activeState(activeState), .inS(inS), .timeoutPulse(timeoutPulse)
  );

  function automatic logic [NS:0] oneHot(int idx);
    logic [NS:0] v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  task automatic check(string tag, logic [NS:0] expState, bit expPulse);
    compared++;
    if (activeState !== expState || inS !== (expState[NS] == 1'b0)
        || timeoutPulse !== expPulse) begin
      mismatched++;
      $display("FAIL %s: state=%b inS=%b pulse=%b expected state=%b inS=%b pulse=%b",
               tag, activeState, inS, timeoutPulse, expState, !expState[NS], expPulse);
    end
  endtask

  // Reference step, built from the requirements; all values use pre-edge state
  task automatic modelStep(bit d, bit h, bit x, bit adv, bit w);
    int nxt = mState;
    bit fire = 0;
    if (mState == OUT) begin
      if (d)      nxt = 0;                                // R3, R9
      else if (h) nxt = mHistValid ? mHist : 0;           // R4
    end else begin
      if (x) begin nxt = OUT; mHist = mState; mHistValid = 1; end  // R5
      else if (adv) nxt = (mState == NS-1) ? 0 : mState + 1;       // R6
      else if (mState == 0 && !w && mCnt == TO-1) begin nxt = 3; fire = 1; end // R7
    end
    mCnt   = (mState == 0 && nxt == 0 && !w) ? mCnt + 1 : 0;
    mState = nxt;
    mPulse = fire;
  endtask

  task automatic step(string tag, bit d, bit h, bit x, bit adv, bit w);
    evEnterDef = d; evEnterHist = h; evExit = x; evAdvance = adv; evWatch = w;
    modelStep(d, h, x, adv, w);
    @(posedge clk);
    #1;
    evEnterDef = 0; evEnterHist = 0; evExit = 0; evAdvance = 0; evWatch = 0;
    check(tag, oneHot(mState), mPulse);
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    mState = OUT; mHist = 0; mCnt = 0; mHistValid = 0; mPulse = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check("R2 reset state", 6'b100000, 1'b0);

    // R8: events of the inner level while Idle
    step("R8 exit at Idle", 0, 0, 1, 0, 0);
    step("R8 step at Idle", 0, 0, 0, 1, 1);
    check("R8 still Idle", 6'b100000, 1'b0);

    // R4: resume with empty memory falls back to substate 0
    step("R4 empty resume", 0, 1, 0, 0, 0);
    check("R4 empty resume lands 0", oneHot(0), 1'b0);

    // R6: full ring
    for (int k = 1; k <= NS; k++) step("R6 ring step", 0, 0, 0, 1, 0);
    check("R6 wrap to 0", oneHot(0), 1'b0);

    // R8: entry while inside has no effect
    step("R6 to 1", 0, 0, 0, 1, 0);
    step("R8 entry inside", 1, 1, 0, 0, 0);
    check("R8 entry ignored inside", oneHot(1), 1'b0);

    // R4: leave from 2, resume to 2
    step("R6 to 2", 0, 0, 0, 1, 0);
    step("R5 leave", 0, 0, 1, 0, 0);
    step("R4 resume", 0, 1, 0, 0, 0);
    check("R4 resume to 2", oneHot(2), 1'b0);

    // R5: leave and step together record the pre-step substate
    step("R5 leave+step", 0, 0, 1, 1, 0);
    check("R5 leave wins", 6'b100000, 1'b0);
    step("R4 resume after leave+step", 0, 1, 0, 0, 0);
    check("R5 recorded pre-step substate", oneHot(2), 1'b0);

    // R3: plain entry ignores memory; R9 plain beats resume
    step("R5 leave", 0, 0, 1, 0, 0);
    step("R9 both entries", 1, 1, 0, 0, 0);
    check("R9 plain wins", oneHot(0), 1'b0);
    step("R6 to 1", 0, 0, 0, 1, 0);
    step("R5 leave", 0, 0, 1, 0, 0);
    step("R3 plain entry", 1, 0, 0, 0, 0);
    check("R3 plain lands 0", oneHot(0), 1'b0);

    // R7: timeout after exactly TO cycles; the first cycle in 0 was just shown
    for (int k = 1; k < TO; k++) step("R7 dwell", 0, 0, 0, 0, 0);
    check("R7 still supervised before limit", oneHot(0), 1'b0);
    step("R7 timeout edge", 0, 0, 0, 0, 0);
    check("R7 target with pulse", oneHot(3), 1'b1);
    step("R7 pulse drops", 0, 0, 0, 0, 0);
    check("R7 pulse one cycle", oneHot(3), 1'b0);

    // R7: keep-alive restarts the count
    step("R5 leave", 0, 0, 1, 0, 0);
    step("R3 enter", 1, 0, 0, 0, 0);
    for (int k = 1; k < TO; k++) step("R7 dwell", 0, 0, 0, 0, 0);
    step("R7 keep-alive", 0, 0, 0, 0, 1);
    check("R7 keep-alive holds 0", oneHot(0), 1'b0);
    for (int k = 1; k < TO; k++) step("R7 dwell after restart", 0, 0, 0, 0, 0);
    check("R7 restarted count", oneHot(0), 1'b0);

    // R5: leave beats a due timeout and records substate 0
    step("R5 leave at due timeout", 0, 0, 1, 0, 0);
    check("R5 leave beats timeout", 6'b100000, 1'b0);
    step("R4 resume", 0, 1, 0, 0, 0);
    check("R5 recorded 0", oneHot(0), 1'b0);

    // Random traffic compared against the reference, every cycle
    for (int n = 0; n < 4000; n++) begin
      bit d = ($urandom % 10) == 0;
      bit h = ($urandom % 8) == 0;
      bit x = ($urandom % 12) == 0;
      bit a = ($urandom % 6) == 0;
      bit w = ($urandom % 40) == 0;
      step("R1 random", d, h, x, a, w);
    end

    // R2: reset mid-run returns to Idle with empty memory
    rst = 1;
    @(posedge clk);
    #1 rst = 0;
    mState = OUT; mHistValid = 0; mCnt = 0; mPulse = 0;
    check("R2 reset again", 6'b100000, 1'b0);
    step("R2 resume after reset", 0, 1, 0, 0, 0);
    check("R2 memory cleared", oneHot(0), 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule